// File: doc/BRIEF.md
# GPIO Bank Output Latch and Pad Datapath

This block holds the general-purpose pins of one device: up to 64 pins per bank, with as many banks as the pin count needs. Software drives the pins through a 64-bit register bus with separate write and read channels. The output latch has no plain write path. Software raises latch bits through a write-1-to-set port and lowers them through a write-1-to-clear port, so two agents can each update their own pins without a read-modify-write race.

Each pin has its own configuration word with these fields:
- an output enable;
- a polarity inversion, which applies to both the driven level and the sampled level;
- an open-drain select;
- an ownership field. A nonzero value in it hands the pin to another function, and the GPIO path then does not drive the pin.

Pad inputs pass through a two-flop synchroniser before they can be read back. A read-only constant word reports the pin count and the base interrupt vector index. That index is used by the neighbouring interrupt block, which sits outside this project, as does glitch filtering.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output latch and every pin configuration are 0, no pad is enabled (`pad_oe` all 0) and `rd_data` is 0.
- R2: A write to the set port (bank base + 0x8) sets every latch bit of that bank whose data bit is 1. Bits written as 0 keep their value. With no write, the latch does not change.
- R3: A write to the clear port (bank base + 0x10) clears every latch bit of that bank whose data bit is 1. Bits written as 0 keep their value.
- R4: A read of the set port returns the bank's latch contents, and a read of the clear port returns 0. `rd_data` is updated on the clock edge after `rd_en` and holds while `rd_en` is low. A read and a write to the same port in the same cycle return the latch value from before the write.
- R5: Pin p's configuration word is at byte address 0x400 + 8·p. Its fields are: bit 0 output enable, bit 1 inversion, bit 12 open-drain, bits 25:16 owner select. Every other bit is ignored on write and reads back as 0.
- R6: In push-pull mode, with output enable 1, owner select 0 and open-drain 0, the pad is driven (`pad_oe`=1) and `pad_out` equals the latch bit XOR the inversion bit.
- R7: In open-drain mode the pad is driven low (`pad_oe`=1, `pad_out`=0) when latch XOR inversion is 0. It is released (`pad_oe`=0) when that value is 1. An open-drain pin never drives high.
- R8: A pin with a nonzero owner select or with output enable 0 is never driven (`pad_oe`=0).
- R9: A read of the receive port (bank base + 0x0) returns each pin's synchronised `pad_in` XOR its inversion bit. A pad change becomes visible to a read issued two or more cycles after the change.
- R10: The constant word at 0x90 holds the pin count in bits 7:0 and `VEC_BASE` in bits 15:8. All other bits are 0.
- R11: Bank k sits at k·0x1400 with the same receive, set and clear layout. Bits above the last existing pin read 0 and cannot be set.
- R12: Reads of unmapped or misaligned addresses return 0, and writes to them, to the receive port or to the constant word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 64 | Registered read data |
| pad_in | input | N_PINS | Asynchronous pad input levels |
| pad_out | output | N_PINS | Pad output levels |
| pad_oe | output | N_PINS | Pad output enables |

## Verification
The read and write channels are independent, so a read of the set port can fall in the same cycle as a set write to that port. The bench drives both strobes on one clock edge. It expects the captured read to show the latch before the write, and a later read to show the merged value. Configuration writes also land while the latch holds a value. The bench judges the pad outputs in the cycle after each configuration or latch change against the level computed from the latch, inversion and drive mode.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and types of the GPIO bank.
// Assumes byte addressing with 8-byte aligned registers.
package gpio_bank_pkg;
    localparam int unsigned OFS_RX       = 32'h0000;
    localparam int unsigned OFS_SET      = 32'h0008;
    localparam int unsigned OFS_CLR      = 32'h0010;
    localparam int unsigned OFS_CONST    = 32'h0090;
    localparam int unsigned OFS_CFG_BASE = 32'h0400;
    localparam int unsigned BANK_STRIDE  = 32'h1400;
    localparam int unsigned BANK_W       = 64;
    localparam int unsigned OWN_W        = 10;

    // Stored part of one pin configuration word
    typedef struct packed {
        logic [OWN_W-1:0] own;
        logic             od;
        logic             inv;
        logic             oe;
    } pin_cfg_t;
endpackage

// File: rtl/gpio_addr_dec.sv
// Address decoder: maps a byte address to one register of the bank.
// Assumes ADDR_W is wide enough for every bank base and the config window.
module gpio_addr_dec #(
    parameter int N_PINS  = 80,
    parameter int N_BANKS = 2,
    parameter int ADDR_W  = 16,
    parameter int PIN_W   = 7
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [N_BANKS-1:0] hit_rx,
    output logic [N_BANKS-1:0] hit_set,
    output logic [N_BANKS-1:0] hit_clr,
    output logic               hit_const,
    output logic               hit_cfg,
    output logic [PIN_W-1:0]   cfg_idx
);
    import gpio_bank_pkg::*;

    localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(OFS_CFG_BASE);
    localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(OFS_CFG_BASE + 8 * N_PINS);
    localparam logic [ADDR_W-1:0] A_CST  = ADDR_W'(OFS_CONST);

    // Per-bank data port compares
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] A_RX  = ADDR_W'(b * BANK_STRIDE + OFS_RX);
        localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(b * BANK_STRIDE + OFS_SET);
        localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(b * BANK_STRIDE + OFS_CLR);
        assign hit_rx[b]  = (addr == A_RX);
        assign hit_set[b] = (addr == A_SET);
        assign hit_clr[b] = (addr == A_CLR);
    end

    // Constant word and the aligned config window
    assign hit_const = (addr == A_CST);
    assign hit_cfg   = (addr >= CFG_LO) && (addr < CFG_HI) && (addr[2:0] == 3'b000);
    assign cfg_idx   = PIN_W'((addr - CFG_LO) >> 3);
endmodule

// File: rtl/gpio_out_latch.sv
// Output latch: bits change only through write-1-to-set and write-1-to-clear.
// Assumes at most one of the set and clear hits is active per cycle.
module gpio_out_latch #(
    parameter int N_PINS  = 80,
    parameter int N_BANKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [N_BANKS-1:0] set_hit,
    input  logic [N_BANKS-1:0] clr_hit,
    input  logic [63:0]        wdata,
    output logic [N_PINS-1:0]  latch_q
);
    import gpio_bank_pkg::*;

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        localparam int B = p / BANK_W;
        localparam int I = p % BANK_W;
        logic do_set;
        logic do_clr;
        assign do_set = wr_en && set_hit[B] && wdata[I];
        assign do_clr = wr_en && clr_hit[B] && wdata[I];

        // Apply set or clear strobe to one latch bit
        always_ff @(posedge clk) begin
            if (!rst_n)      latch_q[p] <= 1'b0;
            else if (do_set) latch_q[p] <= 1'b1;
            else if (do_clr) latch_q[p] <= 1'b0;
        end
    end
endmodule

// File: rtl/gpio_pin_cfg.sv
// Per-pin configuration storage with flattened control vectors.
// Assumes idx is in range whenever hit is set.
module gpio_pin_cfg #(
    parameter int N_PINS = 80,
    parameter int PIN_W  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     hit,
    input  logic [PIN_W-1:0]         idx,
    input  gpio_bank_pkg::pin_cfg_t  wcfg,
    output gpio_bank_pkg::pin_cfg_t  cfg_arr [N_PINS],
    output logic [N_PINS-1:0]        oe_v,
    output logic [N_PINS-1:0]        inv_v,
    output logic [N_PINS-1:0]        od_v,
    output logic [N_PINS-1:0]        owned_v
);
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic sel_me;
        assign sel_me = wr_en && hit && (idx == PIN_W'(p));

        // Store the configuration word of one pin
        always_ff @(posedge clk) begin
            if (!rst_n)      cfg_arr[p] <= '0;
            else if (sel_me) cfg_arr[p] <= wcfg;
        end

        assign oe_v[p]    = cfg_arr[p].oe;
        assign inv_v[p]   = cfg_arr[p].inv;
        assign od_v[p]    = cfg_arr[p].od;
        assign owned_v[p] = |cfg_arr[p].own;
    end
endmodule

// File: rtl/gpio_pad_ctl.sv
// Pad control: drive mode, polarity and the input synchroniser.
// Assumes pad_in is asynchronous to clk.
module gpio_pad_ctl #(
    parameter int N_PINS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] latch_q,
    input  logic [N_PINS-1:0] oe_v,
    input  logic [N_PINS-1:0] inv_v,
    input  logic [N_PINS-1:0] od_v,
    input  logic [N_PINS-1:0] owned_v,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] rx_val
);
    logic [N_PINS-1:0] sync1;
    logic [N_PINS-1:0] sync2;

    // Two-flop synchroniser for the pad inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= pad_in;
            sync2 <= sync1;
        end
    end

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic eff;
        logic may_drive;
        assign eff       = latch_q[p] ^ inv_v[p];
        assign may_drive = oe_v[p] && !owned_v[p];

        // Push-pull drives both levels; open-drain only pulls low
        always_comb begin
            if (od_v[p]) begin
                pad_out[p] = 1'b0;
                pad_oe[p]  = may_drive && !eff;
            end else begin
                pad_out[p] = eff;
                pad_oe[p]  = may_drive;
            end
        end

        assign rx_val[p] = sync2[p] ^ inv_v[p];
    end
endmodule

// File: rtl/gpio_bank.sv
// GPIO bank top: decodes both bus channels, hosts the latch, the
// configuration and the pad logic, and registers read data.
// Assumes one write and one read per cycle at most.
module gpio_bank #(
    parameter int N_PINS   = 80,
    parameter int ADDR_W   = 16,
    parameter int VEC_BASE = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe
);
    import gpio_bank_pkg::*;

    localparam int N_BANKS = (N_PINS + BANK_W - 1) / BANK_W;
    localparam int PIN_W   = (N_PINS > 1) ? $clog2(N_PINS) : 1;
    localparam int PAD_W   = N_BANKS * BANK_W;

    logic [N_BANKS-1:0] wr_hit_rx, wr_hit_set, wr_hit_clr;
    logic [N_BANKS-1:0] rd_hit_rx, rd_hit_set, rd_hit_clr;
    logic               wr_hit_const, wr_hit_cfg, rd_hit_const, rd_hit_cfg;
    logic [PIN_W-1:0]   wr_idx, rd_idx;
    logic               wr_act;
    pin_cfg_t           wr_cfg;
    pin_cfg_t           cfg_arr [N_PINS];
    logic [N_PINS-1:0]  latch_q, oe_v, inv_v, od_v, owned_v, rx_val;
    logic [PAD_W-1:0]   latch_w, rx_w;
    logic [63:0]        rd_next;

    gpio_addr_dec #(.N_PINS(N_PINS), .N_BANKS(N_BANKS), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_wdec (
        .addr(wr_addr), .hit_rx(wr_hit_rx), .hit_set(wr_hit_set), .hit_clr(wr_hit_clr),
        .hit_const(wr_hit_const), .hit_cfg(wr_hit_cfg), .cfg_idx(wr_idx)
    );

    gpio_addr_dec #(.N_PINS(N_PINS), .N_BANKS(N_BANKS), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_rdec (
        .addr(rd_addr), .hit_rx(rd_hit_rx), .hit_set(rd_hit_set), .hit_clr(rd_hit_clr),
        .hit_const(rd_hit_const), .hit_cfg(rd_hit_cfg), .cfg_idx(rd_idx)
    );

    // Writes to read-only words are dropped
    assign wr_act = wr_en && !(|wr_hit_rx) && !wr_hit_const;

    // Extract the stored configuration fields from the write word
    always_comb begin
        wr_cfg     = '0;
        wr_cfg.oe  = wr_data[0];
        wr_cfg.inv = wr_data[1];
        wr_cfg.od  = wr_data[12];
        wr_cfg.own = wr_data[25:16];
    end

    gpio_out_latch #(.N_PINS(N_PINS), .N_BANKS(N_BANKS)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_act), .set_hit(wr_hit_set),
        .clr_hit(wr_hit_clr), .wdata(wr_data), .latch_q(latch_q)
    );

    gpio_pin_cfg #(.N_PINS(N_PINS), .PIN_W(PIN_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_act), .hit(wr_hit_cfg), .idx(wr_idx),
        .wcfg(wr_cfg), .cfg_arr(cfg_arr), .oe_v(oe_v), .inv_v(inv_v),
        .od_v(od_v), .owned_v(owned_v)
    );

    gpio_pad_ctl #(.N_PINS(N_PINS)) u_pad (
        .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .oe_v(oe_v), .inv_v(inv_v),
        .od_v(od_v), .owned_v(owned_v), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .rx_val(rx_val)
    );

    // Zero-pad latch and receive values to whole banks
    always_comb begin
        latch_w              = '0;
        rx_w                 = '0;
        latch_w[N_PINS-1:0]  = latch_q;
        rx_w[N_PINS-1:0]     = rx_val;
    end

    // Select the read word for the read address
    always_comb begin
        pin_cfg_t c;
        rd_next = '0;
        c       = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (rd_hit_rx[b])  rd_next = rx_w[b*BANK_W +: BANK_W];
            if (rd_hit_set[b]) rd_next = latch_w[b*BANK_W +: BANK_W];
            if (rd_hit_clr[b]) rd_next = '0;
        end
        if (rd_hit_const) begin
            rd_next[7:0]  = 8'(N_PINS);
            rd_next[15:8] = 8'(VEC_BASE);
        end
        if (rd_hit_cfg) begin
            c              = cfg_arr[rd_idx];
            rd_next[0]     = c.oe;
            rd_next[1]     = c.inv;
            rd_next[12]    = c.od;
            rd_next[25:16] = c.own;
        end
    end

    // Register the read word on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/gpio_bank_chk.sv
// Assertion checker for gpio_bank, attached by bind.
// Assumes bank 0 port offsets from the package.
module gpio_bank_chk #(
    parameter int N_PINS = 80,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_en,
    input logic [63:0]       rd_data,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] latch_q,
    input logic [N_PINS-1:0] od_v
);
    import gpio_bank_pkg::*;

    AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFS_SET)) |=> ((latch_q & $past(latch_q)) == $past(latch_q))); // R2
    AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFS_CLR)) |=> ((latch_q | $past(latch_q)) == $past(latch_q))); // R3
    AST_LATCH_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(latch_q)); // R2
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & od_v) == '0)); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R4
endmodule

bind gpio_bank gpio_bank_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en),
    .rd_data(rd_data), .pad_out(pad_out), .pad_oe(pad_oe), .latch_q(latch_q), .od_v(od_v)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N_PINS     = 80;
    localparam int ADDR_W     = 16;
    localparam int WD_CYCLES  = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [63:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [63:0]       rd_data;
    logic [N_PINS-1:0] pad_in = '0;
    logic [N_PINS-1:0] pad_out;
    logic [N_PINS-1:0] pad_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .VEC_BASE(48)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [63:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        check(128'(rd_data), 128'h0, "R1", "rd_data after reset");
        check(128'(pad_oe), 128'h0, "R1", "pad_oe after reset");
        rd(16'h0008, v);
        check(128'(v), 128'h0, "R1", "latch after reset");
        rd(16'h0420, v);
        check(128'(v), 128'h0, "R1", "pin 4 config after reset");
    endtask

    task automatic t_set_clear();
        logic [63:0] v;
        wr(16'h0008, 64'h0000_00FF_0000_F00F);
        rd(16'h0008, v);
        check(128'(v), 128'h0000_00FF_0000_F00F, "R2", "first set");
        wr(16'h0008, 64'h1100_0000_0000_0000);
        rd(16'h0008, v);
        check(128'(v), 128'h1100_00FF_0000_F00F, "R2", "second set keeps zero-bits");
        wr(16'h0010, 64'h0000_000F_0000_000F);
        rd(16'h0008, v);
        check(128'(v), 128'h1100_00F0_0000_F000, "R3", "clear selected bits");
        rd(16'h0010, v);
        check(128'(v), 128'h0, "R4", "clear port reads 0");
    endtask

    task automatic t_same_cycle();
        logic [63:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h0008; wr_data = 64'h0000_0000_0000_0F00;
        rd_en = 1'b1; rd_addr = 16'h0008;
        @(negedge clk);
        v = rd_data;
        wr_en = 1'b0; rd_en = 1'b0;
        check(128'(v), 128'h1100_00F0_0000_F000, "R4", "same-cycle read sees old latch");
        check(128'(rd_data), 128'h1100_00F0_0000_F000, "R4", "rd_data holds while idle");
        rd(16'h0008, v);
        check(128'(v), 128'h1100_00F0_0000_FF00, "R4", "later read sees merged latch");
        wr(16'h0010, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(16'h0008, v);
        check(128'(v), 128'h0, "R3", "clear all");
    endtask

    task automatic t_cfg();
        logic [63:0] v;
        wr(16'h0418, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(16'h0418, v);
        check(128'(v), 128'h0000_0000_03FF_1003, "R5", "config fields only");
        check(128'(pad_oe), 128'h0, "R8", "owned pin 3 not driven");
        wr(16'h0418, 64'h0);
        rd(16'h0418, v);
        check(128'(v), 128'h0, "R5", "config cleared");
    endtask

    task automatic t_push_pull();
        wr(16'h0428, 64'h1);
        check(128'(pad_oe), 128'(80'h20), "R6", "pin 5 enabled");
        check(128'(pad_out[5]), 128'h0, "R6", "pin 5 low from latch 0");
        wr(16'h0008, 64'h20);
        check(128'(pad_out[5]), 128'h1, "R6", "pin 5 high from latch 1");
        wr(16'h0428, 64'h3);
        check(128'(pad_out[5]), 128'h0, "R6", "pin 5 inverted");
        check(128'(pad_oe[5]), 128'h1, "R6", "pin 5 still driven");
    endtask

    task automatic t_open_drain();
        wr(16'h0430, 64'h1001);
        check(128'(pad_oe[6]), 128'h1, "R7", "od pulls low when latch 0");
        check(128'(pad_out[6]), 128'h0, "R7", "od level low");
        wr(16'h0008, 64'h40);
        check(128'(pad_oe[6]), 128'h0, "R7", "od releases when latch 1");
        wr(16'h0430, 64'h1003);
        check(128'(pad_oe[6]), 128'h1, "R7", "od inverted pulls low");
        check(128'(pad_out[6]), 128'h0, "R7", "od inverted level low");
    endtask

    task automatic t_owned();
        wr(16'h0428, 64'h0003_0001);
        check(128'(pad_oe[5]), 128'h0, "R8", "owner select blocks drive");
        wr(16'h0430, 64'h1000);
        check(128'(pad_oe[6]), 128'h0, "R8", "oe 0 blocks drive");
        wr(16'h0428, 64'h0);
        wr(16'h0430, 64'h0);
        wr(16'h0010, 64'hFFFF_FFFF_FFFF_FFFF);
        check(128'(pad_oe), 128'h0, "R8", "all released");
    endtask

    task automatic t_rx();
        logic [63:0] v;
        wr(16'h0410, 64'h2);
        @(negedge clk);
        pad_in = {16'hBEEF, 64'hA5A5_0000_1234_5678};
        @(negedge clk);
        @(negedge clk);
        rd(16'h0000, v);
        check(128'(v), 128'hA5A5_0000_1234_567C, "R9", "bank 0 receive with pin 2 inverted");
        rd(16'h1400, v);
        check(128'(v), 128'hBEEF, "R11", "bank 1 receive, upper bits 0");
        wr(16'h0410, 64'h0);
        rd(16'h0000, v);
        check(128'(v), 128'hA5A5_0000_1234_5678, "R9", "receive without inversion");
    endtask

    task automatic t_const();
        logic [63:0] v;
        rd(16'h0090, v);
        check(128'(v), 128'h3050, "R10", "constant word");
        wr(16'h0090, 64'hFFFF);
        rd(16'h0090, v);
        check(128'(v), 128'h3050, "R12", "constant ignores writes");
    endtask

    task automatic t_bank1();
        logic [63:0] v;
        wr(16'h1408, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(16'h1408, v);
        check(128'(v), 128'hFFFF, "R11", "bank 1 set limited to existing pins");
        rd(16'h0008, v);
        check(128'(v), 128'h0, "R11", "bank 0 untouched by bank 1 set");
        wr(16'h0600, 64'h1);
        check(128'(pad_oe), 128'(80'h1 << 64), "R11", "pin 64 driven");
        check(128'(pad_out[64]), 128'h1, "R11", "pin 64 high");
        wr(16'h1410, 64'h1);
        rd(16'h1408, v);
        check(128'(v), 128'hFFFE, "R11", "bank 1 clear");
        check(128'(pad_out[64]), 128'h0, "R11", "pin 64 low");
        wr(16'h0600, 64'h0);
        wr(16'h1410, 64'hFFFF);
    endtask

    task automatic t_unmapped();
        logic [63:0] v;
        wr(16'h0018, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(16'h0000, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(16'h0008, v);
        check(128'(v), 128'h0, "R12", "unmapped and receive writes leave latch");
        rd(16'h0018, v);
        check(128'(v), 128'h0, "R12", "unmapped read");
        wr(16'h0680, 64'h1);
        rd(16'h0680, v);
        check(128'(v), 128'h0, "R12", "config past last pin");
        wr(16'h0404, 64'h1);
        rd(16'h0400, v);
        check(128'(v), 128'h0, "R12", "misaligned config write ignored");
        check(128'(pad_oe), 128'h0, "R12", "no pad enabled");
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_same_cycle();
        t_cfg();
        t_push_pull();
        t_open_drain();
        t_owned();
        t_rx();
        t_const();
        t_bank1();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule